// File: doc/BRIEF.md
# Timeout Watchdog With Supervisor Gating

This block is a synchronous timeout watchdog that sits next to a supply supervisor. Two comparator flags tell it whether the supply is above the lower threshold and above the upper threshold; the band between them forms a hysteresis window. When the supply first clears the upper threshold, the block holds its reset output low for a fixed reset-delay period. It then allows the host a startup delay to boot, and after that it starts timing the host's service kicks.

A kick is a falling edge on an asynchronous input. That input passes through a two-flop synchronizer before the edge detector sees it. Each kick restarts the timeout window. If a full window passes with no kick, the block drives a fault pulse that lasts exactly the reset-delay period. A routing input decides where the pulse goes. On the reset line, the startup delay is applied again once the pulse ends. On the separate fault line, monitoring resumes at once with a fresh window. Dropping below the lower threshold resets everything. Clearing the enable pauses the watchdog quietly. All timing values are parameters counted in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: While `sup_lo` is low, `rst_out_n` is low and `wdo_n` is high. If `sup_lo` falls, `rst_out_n` is low at the first clock edge after the fall, including during a fault pulse, and all counters clear.
- R2: With `sup_lo` high and `sup_hi` low after a power loss, `rst_out_n` stays low. Once `sup_hi` is high, `rst_out_n` is held low for exactly RST_DLY cycles and is then released.
- R3: After `rst_out_n` is released, a startup delay of START_DLY cycles runs before timeout counting begins. With no kicks, the first fault pulse therefore starts START_DLY+TIMEOUT cycles after release.
- R4: Only a falling edge of `kick_n` counts as a kick, seen after a two-flop synchronizer. A kick restarts the window, so the next timeout comes TIMEOUT+3 cycles after the input falls. Rising edges and a steady low level have no effect.
- R5: When TIMEOUT cycles pass without a kick, a fault pulse is raised. It appears on `rst_out_n` when `route_fault` is 0 and on `wdo_n` when `route_fault` is 1. The other output stays high.
- R6: A fault pulse keeps its output low for exactly RST_DLY cycles.
- R7: After a pulse on `rst_out_n`, the startup delay runs again, so the next pulse follows START_DLY+TIMEOUT cycles later. After a pulse on `wdo_n`, a fresh window starts at once, so the next pulse follows TIMEOUT cycles later.
- R8: While `wd_en` is low, the timeout counter is held at zero and neither output falls. Raising `wd_en` starts a fresh window that ends in a pulse TIMEOUT cycles later.
- R9: Both outputs are registered and are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| kick_n | input | 1 | Asynchronous service input; a falling edge is a kick |
| wd_en | input | 1 | Watchdog enable, active high |
| sup_hi | input | 1 | Supply above upper threshold |
| sup_lo | input | 1 | Supply above lower threshold; low clears the block |
| route_fault | input | 1 | 0: timeout drives `rst_out_n`; 1: timeout drives `wdo_n` |
| rst_out_n | output | 1 | Reset output, active low, registered |
| wdo_n | output | 1 | Watchdog fault output, active low, registered |

## Verification
The one shared counter and the phase register decide every output edge. A counter that clears at the wrong time, or a phase that moves on too early, therefore shows up at the ports as a low or high interval that is off by some cycles. The bench measures each interval exactly, cycle by cycle: the power-up hold, the startup-plus-window gap, the pulse width and the gap between pulses. Any error is seen within one window. The bench also counts the latency from a kick or an enable to the next fault edge, which exposes a wrong synchronizer depth or a rising edge wrongly accepted as a kick. It catches an output that is stuck or on the wrong line at the first expected edge.

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int TIMEOUT   = 20,
  parameter int RST_DLY   = 8,
  parameter int START_DLY = 12
) (
  input  logic clk,
  input  logic kick_n,
  input  logic wd_en,
  input  logic sup_hi,
  input  logic sup_lo,
  input  logic route_fault,
  output logic rst_out_n,
  output logic wdo_n
);
  localparam int MAXC = (TIMEOUT > RST_DLY) ? ((TIMEOUT > START_DLY) ? TIMEOUT : START_DLY)
                                            : ((RST_DLY > START_DLY) ? RST_DLY : START_DLY);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_BOOT, S_WATCH, S_PRST, S_PWDO} st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic [2:0]    ksync;
  logic          rst_q, wdo_q;

  wire fall = ksync[2] & ~ksync[1];
  assign rst_out_n = rst_q;
  assign wdo_n     = wdo_q;

  always_comb begin
    nst  = st;
    ncnt = cnt + 1'b1;
    case (st)
      S_OFF: begin
        ncnt = '0;
        if (sup_hi) nst = S_HOLD;
      end
      S_HOLD, S_PRST: if (cnt == CW'(RST_DLY - 1)) begin
        nst = S_BOOT; ncnt = '0;
      end
      S_BOOT: if (cnt == CW'(START_DLY - 1)) begin
        nst = S_WATCH; ncnt = '0;
      end
      S_WATCH: begin
        if (!wd_en || fall) ncnt = '0;
        else if (cnt == CW'(TIMEOUT - 1)) begin
          nst  = route_fault ? S_PWDO : S_PRST;
          ncnt = '0;
        end
      end
      S_PWDO: if (cnt == CW'(RST_DLY - 1)) begin
        nst = S_WATCH; ncnt = '0;
      end
      default: begin nst = S_OFF; ncnt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!sup_lo) begin
      st    <= S_OFF;
      cnt   <= '0;
      ksync <= 3'b111;
      rst_q <= 1'b0;
      wdo_q <= 1'b1;
    end else begin
      st    <= nst;
      cnt   <= ncnt;
      ksync <= {ksync[1:0], kick_n};
      rst_q <= !(nst inside {S_OFF, S_HOLD, S_PRST});
      wdo_q <= (nst != S_PWDO);
    end
  end

  assert_rst_on_recover_R1: assert property (@(posedge clk) disable iff (!sup_lo)
    $rose(sup_lo) |-> !rst_out_n);

  assert_kick_restarts_R4: assert property (@(posedge clk) disable iff (!sup_lo)
    (st == S_WATCH && fall) |=> (st == S_WATCH && cnt == '0));

  assert_fault_origin_R5: assert property (@(posedge clk) disable iff (!sup_lo)
    $fell(wdo_n) |-> ($past(st) == S_WATCH && $past(route_fault) && $past(cnt) == CW'(TIMEOUT - 1)));

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!sup_lo)
    ($rose(wdo_n) && $past(sup_lo)) |-> ($past(st) == S_PWDO && $past(cnt) == CW'(RST_DLY - 1)));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!sup_lo)
    (st == S_WATCH && !wd_en) |=> (rst_out_n && wdo_n));

  assert_not_both_low_R9: assert property (@(posedge clk) disable iff (!sup_lo)
    !(!rst_out_n && !wdo_n));
endmodule

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;
  localparam int T = 20, RD = 8, SD = 12;

  logic clk = 1'b0;
  logic kick_n, wd_en, sup_hi, sup_lo, route_fault;
  logic rst_out_n, wdo_n;
  int n_chk = 0, n_fail = 0, both_low = 0;

  always #5 clk = ~clk;

  wdt_supervisor #(.TIMEOUT(T), .RST_DLY(RD), .START_DLY(SD)) i_wdt_supervisor (
    .clk(clk), .kick_n(kick_n), .wd_en(wd_en), .sup_hi(sup_hi), .sup_lo(sup_lo),
    .route_fault(route_fault), .rst_out_n(rst_out_n), .wdo_n(wdo_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit use_wdo, input bit lvl, output int n);
    n = 0;
    while (((use_wdo ? wdo_n : rst_out_n) == lvl) && n < 1000) begin
      if (!rst_out_n && !wdo_n) both_low++;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset(input bit rte);
    sup_lo = 0; sup_hi = 0; kick_n = 1; wd_en = 1; route_fault = rte;
    repeat (5) @(negedge clk);
    chk(rst_out_n == 0, "R1 reset low", rst_out_n, 0);
    chk(wdo_n == 1, "R1 fault high in reset", wdo_n, 1);
    sup_lo = 1;
    repeat (10) @(negedge clk);
    chk(rst_out_n == 0, "R2 held without upper flag", rst_out_n, 0);
  endtask

  task automatic t_rst_route;
    int n;
    t_reset(0);
    sup_hi = 1;
    @(negedge clk);
    measure(0, 0, n); chk(n == RD, "R2 power-up hold", n, RD);
    measure(0, 1, n); chk(n == SD + T, "R3 startup plus window", n, SD + T);
    chk(wdo_n == 1, "R5 fault line idle on reset route", wdo_n, 1);
    measure(0, 0, n); chk(n == RD, "R6 reset pulse width", n, RD);
    measure(0, 1, n); chk(n == SD + T, "R7 startup reapplied", n, SD + T);
  endtask

  task automatic t_wdo_route;
    int n;
    t_reset(1);
    sup_hi = 1;
    @(negedge clk);
    measure(0, 0, n); chk(n == RD, "R2 power-up hold", n, RD);
    measure(1, 1, n); chk(n == SD + T, "R3 startup plus window", n, SD + T);
    chk(rst_out_n == 1, "R5 reset idle on fault route", rst_out_n, 1);
    measure(1, 0, n); chk(n == RD, "R6 fault pulse width", n, RD);
    measure(1, 1, n); chk(n == T, "R7 fresh window after fault", n, T);
    measure(1, 0, n);
  endtask

  task automatic t_kick;
    int faults = 0, n = 0;
    repeat (8) begin
      kick_n = 0;
      repeat (2) begin @(negedge clk); if (!wdo_n || !rst_out_n) faults++; end
      kick_n = 1;
      repeat (8) begin @(negedge clk); if (!wdo_n || !rst_out_n) faults++; end
    end
    chk(faults == 0, "R4 regular kicks keep quiet", faults, 0);
    kick_n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 8) kick_n = 1;
    end while (wdo_n && n < 200);
    chk(n == T + 3, "R4 rising edge ignored", n, T + 3);
    measure(1, 0, n);
  endtask

  task automatic t_enable;
    int faults = 0, n = 0;
    wd_en = 0;
    repeat (3 * T) begin @(negedge clk); if (!wdo_n || !rst_out_n) faults++; end
    chk(faults == 0, "R8 disabled no fault", faults, 0);
    wd_en = 1;
    do begin @(negedge clk); n++; end while (wdo_n && n < 200);
    chk(n == T, "R8 fresh window on enable", n, T);
  endtask

  task automatic t_brownout;
    int n;
    sup_lo = 0; sup_hi = 0;
    @(negedge clk);
    chk(rst_out_n == 0, "R1 reset within one cycle", rst_out_n, 0);
    chk(wdo_n == 1, "R1 fault pulse aborted", wdo_n, 1);
    repeat (3) @(negedge clk);
    sup_lo = 1;
    repeat (6) @(negedge clk);
    chk(rst_out_n == 0, "R2 hysteresis hold", rst_out_n, 0);
    sup_hi = 1;
    @(negedge clk);
    measure(0, 0, n); chk(n == RD, "R1 restart power-up", n, RD);
    measure(1, 1, n); chk(n == SD + T, "R1 counters cleared", n, SD + T);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_rst_route;
    t_wdo_route;
    t_kick;
    t_enable;
    t_brownout;
    chk(both_low == 0, "R9 never both low", both_low, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule